// File: doc/BRIEF.md
# Driver and Test-Pattern Enable Latches

This block keeps two 8-bit configuration registers that are written from one shared 8-bit bus. The first register decides, bit by bit, whether each serial line driver is powered. The second decides, bit by bit, whether each line carries a built-in self-test pattern or normal data. Each register has its own active-high load strobe. While a strobe is high, its register takes the bus value on every rising edge of the reference clock. When the strobe drops, the register keeps the last value it took.

The two registers read the bus with opposite polarity. A bus 1 switches a driver on. A bus 0 selects the test pattern for a line. Reset is active low and synchronous to the reference clock, and the two registers treat it differently. The driver register always clears on reset, which turns every driver off. The test register clears only while its strobe is low, which turns the test pattern off on every line. While its strobe is high, the test register ignores reset and keeps following the bus.

All pins are plain control signals with no handshake, because no data stream passes through the block. The outputs come straight from registers, so they hold known values from the first clock edge after reset is applied.

Top module: `line_cfg_latches`

## Requirements
- R1: While `drv_le` is 1 and `rst_n` is 1, each rising clock edge loads `cfg_bus` into the driver register, and `drv_en` equals that bus value after the edge (bit i = 1 turns driver i on).
- R2: While `drv_le` is 0 and `rst_n` is 1, `drv_en` keeps its value, whatever `cfg_bus` or `pat_le` do.
- R3: An edge with `rst_n` = 0 sets `drv_en` to 8'h00, even when `drv_le` is 1.
- R4: While `pat_le` is 1 and `rst_n` is 1, each rising edge loads `cfg_bus`, and after the edge `pat_on` equals the bitwise inverse of that bus value (bus bit 0 selects the test pattern for that line).
- R5: While `pat_le` is 0 and `rst_n` is 1, `pat_on` keeps its value, whatever `cfg_bus` or `drv_le` do.
- R6: An edge with `rst_n` = 0 and `pat_le` = 0 sets `pat_on` to 8'h00.
- R7: An edge with `rst_n` = 0 and `pat_le` = 1 leaves the test register loading: after the edge, `pat_on` equals the inverse of `cfg_bus`.
- R8: When `drv_le` and `pat_le` are both 1, both registers load the same bus value on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; every update happens on its rising edge |
| rst_n | input | 1 | Active-low reset, sampled on the rising edge |
| cfg_bus | input | 8 | Shared configuration bus |
| drv_le | input | 1 | Load strobe for the driver register |
| pat_le | input | 1 | Load strobe for the test-pattern register |
| drv_en | output | 8 | Driver enable for each line, 1 = on |
| pat_on | output | 8 | Test pattern active for each line, 1 = pattern |

## Verification
The bench drives a table of strobe and bus combinations. Asymmetric bus values such as 8'hA5 and 8'h0F show whether each register keeps the right bit positions and the right polarity. Steps that change the bus while a strobe is low tell a held register from one that is still loading. A step with both strobes high shows that the two registers load together. Directed reset steps are then run with the test strobe low and with it high, which separates an unconditional clear from one that only applies while the register is closed.

// File: rtl/line_cfg_pkg.sv
package line_cfg_pkg;
  localparam int unsigned LINES = 8;
  typedef logic [LINES-1:0] line_vec_t;
  // stored image of the pattern register that means "no line in test"
  localparam line_vec_t PAT_IDLE_IMAGE = '1;
  localparam line_vec_t DRV_OFF_IMAGE  = '0;
endpackage

// File: rtl/cfg_hold_reg.sv
module cfg_hold_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RESET_VAL = '0,
  parameter bit CLEAR_WHEN_OPEN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic clear;

  generate
    if (CLEAR_WHEN_OPEN) begin : g_clr_always
      assign clear = !rst_n;
    end else begin : g_clr_closed
      assign clear = !rst_n && !le;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (clear)   q <= RESET_VAL;
    else if (le) q <= d;
  end

  // R1 R4 R7
  load_tracks_bus_chk: assert property (@(posedge clk) disable iff (1'b0)
    (le && !clear) |=> (q == $past(d)));

  // R2 R5
  hold_when_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && rst_n) |=> $stable(q));

  // R3 R6
  clear_to_default_chk: assert property (@(posedge clk) disable iff (1'b0)
    clear |=> (q == RESET_VAL));
endmodule

// File: rtl/cfg_polarity.sv
module cfg_polarity #(
  parameter int unsigned W = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic [W-1:0] stored,
  output logic [W-1:0] active
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (INVERT) begin : g_inv
      assign active[i] = ~stored[i];
    end else begin : g_pass
      assign active[i] = stored[i];
    end
  end
endmodule

// File: rtl/line_cfg_latches.sv
module line_cfg_latches
  import line_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cfg_bus,
  input  logic       drv_le,
  input  logic       pat_le,
  output logic [7:0] drv_en,
  output logic [7:0] pat_on
);
  line_vec_t drv_img, pat_img;

  cfg_hold_reg #(.W(LINES), .RESET_VAL(DRV_OFF_IMAGE), .CLEAR_WHEN_OPEN(1'b1)) u_drv_reg (
    .clk(clk), .rst_n(rst_n), .le(drv_le), .d(cfg_bus), .q(drv_img)
  );

  cfg_hold_reg #(.W(LINES), .RESET_VAL(PAT_IDLE_IMAGE), .CLEAR_WHEN_OPEN(1'b0)) u_pat_reg (
    .clk(clk), .rst_n(rst_n), .le(pat_le), .d(cfg_bus), .q(pat_img)
  );

  cfg_polarity #(.W(LINES), .INVERT(1'b0)) u_drv_pol (.stored(drv_img), .active(drv_en));
  cfg_polarity #(.W(LINES), .INVERT(1'b1)) u_pat_pol (.stored(pat_img), .active(pat_on));

  // R3
  drv_reset_off_chk: assert property (@(posedge clk) disable iff (1'b0)
    !rst_n |=> (drv_en == '0));

  // R6
  pat_reset_idle_chk: assert property (@(posedge clk) disable iff (1'b0)
    (!rst_n && !pat_le) |=> (pat_on == '0));

  // R7
  pat_reset_ignored_chk: assert property (@(posedge clk) disable iff (1'b0)
    (!rst_n && pat_le) |=> (pat_on == ~$past(cfg_bus)));

  // R8
  dual_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_le && pat_le) |=> (drv_en == ~pat_on));
endmodule

// File: tb/tb_line_cfg_latches.sv
module tb_line_cfg_latches;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_bus = '0;
  logic drv_le = 1'b0, pat_le = 1'b0;
  logic [7:0] drv_en, pat_on;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  line_cfg_latches dut (.*);

  // {drv_le, pat_le, bus, exp_drv_en, exp_pat_on}
  localparam logic [25:0] VEC [8] = '{
    {1'b1, 1'b0, 8'hA5, 8'hA5, 8'h00},
    {1'b0, 1'b0, 8'hFF, 8'hA5, 8'h00},
    {1'b0, 1'b1, 8'h0F, 8'hA5, 8'hF0},
    {1'b0, 1'b0, 8'h00, 8'hA5, 8'hF0},
    {1'b1, 1'b1, 8'h3C, 8'h3C, 8'hC3},
    {1'b1, 1'b0, 8'hFF, 8'hFF, 8'hC3},
    {1'b0, 1'b1, 8'hFF, 8'hFF, 8'h00},
    {1'b0, 1'b0, 8'h55, 8'hFF, 8'h00}
  };
  localparam string VTAG [8] = '{"R1", "R2 R5", "R4", "R5 R2", "R8", "R1 R5", "R4 R2", "R2 R5"};

  task automatic check(string tag, logic [7:0] de, logic [7:0] pe);
    checks++;
    if (drv_en !== de || pat_on !== pe) begin
      fails++;
      $display("FAIL %s: drv_en=%h pat_on=%h expected drv_en=%h pat_on=%h", tag, drv_en, pat_on, de, pe);
    end
  endtask

  task automatic step(logic r, logic dl, logic pl, logic [7:0] b);
    @(negedge clk);
    rst_n = r; drv_le = dl; pat_le = pl; cfg_bus = b;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run hung");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    step(1'b0, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 1'b0, 8'h00);
    check("R3 R6 reset state", 8'h00, 8'h00);
    for (int i = 0; i < 8; i++) begin
      step(1'b1, VEC[i][25], VEC[i][24], VEC[i][23:16]);
      check(VTAG[i], VEC[i][15:8], VEC[i][7:0]);
    end
    // R3: reset clears drivers even with drv_le high; R7: pat keeps loading
    step(1'b0, 1'b1, 1'b1, 8'h81);
    check("R3 R7 reset while both open", 8'h00, 8'h7E);
    // R7: change the bus during reset, pattern still follows
    step(1'b0, 1'b0, 1'b1, 8'h0F);
    check("R7 reset ignored by open pattern reg", 8'h00, 8'hF0);
    // R6: closed pattern register clears
    step(1'b0, 1'b0, 1'b0, 8'h00);
    check("R6 reset closed pattern reg", 8'h00, 8'h00);
    // R1: reload after reset
    step(1'b1, 1'b1, 1'b0, 8'h01);
    check("R1 reload after reset", 8'h01, 8'h00);
    // R2: bus toggles with strobes low
    step(1'b1, 1'b0, 1'b0, 8'hFE);
    check("R2 hold with bus toggled", 8'h01, 8'h00);
    // R8: both load all zeros
    step(1'b1, 1'b1, 1'b1, 8'h00);
    check("R8 both load zeros", 8'h00, 8'hFF);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule